// File: doc/BRIEF.md
# Two-Byte-Addressed I2C Register Target with Per-Address Width

This block is an I2C target that lets a bus controller read and write a small register file in the core. After its 7-bit device address, the controller sends a 16-bit register address, high byte first. The block looks that address up in a fixed width table and then moves exactly that many data bytes (one, two or three), most significant byte first. A write reaches the core as a single strobe carrying the whole register value. A read is done by setting the address in a write phase and then issuing a repeated start with the read bit set. The block strobes the core once and holds the returned value while it shifts the bytes out.

SCL and SDA are sampled with the system clock through a synchronizer. The block pulls SDA low by raising a drive-enable output, which an open-drain pad turns into a low level. Accesses to addresses that have no width are refused on the bus, and the core never sees them.

Top module: `i2c_wide_reg_target`

## Requirements
- R1: The target acknowledges a byte after START only when bits 7:1 equal the DEV_ADDR parameter (bit 0 = 1 means read). For any other device byte it does not acknowledge and ignores the bus until the next START.
- R2: The register address arrives as two bytes, high byte first. `reg_addr_o` presents them as {high, low}, and both bytes are acknowledged when the address has a width.
- R3: The register width is 3 bytes at 0x0820 and 0x0821; 2 bytes at 0x081C, 0x081E, 0x0822, 0x0826 and 0x0827; 1 byte at 0x081F. Every other address has no width.
- R4: For an address with no width, the low address byte is not acknowledged and no strobe is issued. A following read through a repeated start is refused at the device byte.
- R5: Write data bytes arrive most significant first. `wr_en_o` pulses for one cycle, once, when the last byte of the register width is acknowledged. `wr_data_o` holds the value right-aligned, with the unused upper bits zero.
- R6: A write that stops before the full width has been received produces no write strobe.
- R7: Any data byte written beyond the register width is not acknowledged and causes no further strobe.
- R8: When a read device byte is acknowledged, `rd_en_o` pulses for one cycle and `rd_data_i` is captured in that cycle. The low register-width bytes of that value are then sent most significant first.
- R9: A read transfer stops after the register width, or after the controller does not acknowledge a byte. Any later byte finds SDA released (reads 0xFF).
- R10: `sda_oe_o` changes only while SCL is low.
- R11: After reset, `sda_oe_o`, `wr_en_o` and `rd_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, SCL/SDA oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rd_data_i | input | 8*DATA_BYTES | Register value for `reg_addr_o`, right-aligned |
| reg_addr_o | output | 16 | Selected register address |
| wr_data_o | output | 8*DATA_BYTES | Write value, right-aligned |
| wr_en_o | output | 1 | One-cycle write strobe |
| rd_en_o | output | 1 | One-cycle read strobe |

## Verification
The checker enforces on every cycle that SDA drive only switches while SCL is low, that both strobes are single-cycle and never overlap, and that a write strobe only targets an address with a defined width and a settled address. The bench scenarios show the rest. A sweep over every defined width and several undefined addresses checks the acknowledge pattern, the byte order in both directions, the right-alignment of data and the released bus after the width. Separate scenarios cover short writes, overlong writes, a foreign device address and an early controller NACK.

// File: rtl/i2c_wide_reg_pkg.sv
package i2c_wide_reg_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_SKIP} state_e;
  typedef enum logic [1:0] {BY_DEV, BY_AHI, BY_ALO, BY_DATA} byte_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges with SCL high on both samples mark bus conditions
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/reg_width_lut.sv
module reg_width_lut #(
  parameter int CNT_W = 2
) (
  input  logic [15:0]      addr_i,
  output logic [CNT_W-1:0] width_o
);
  always_comb begin
    unique case (addr_i)
      16'h0820, 16'h0821:                     width_o = CNT_W'(3);
      16'h081C, 16'h081E, 16'h0822,
      16'h0826, 16'h0827:                     width_o = CNT_W'(2);
      16'h081F:                               width_o = CNT_W'(1);
      default:                                width_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_wide_reg_target.sv
module i2c_wide_reg_target
  import i2c_wide_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h34,
  parameter int         DATA_BYTES  = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic [8*DATA_BYTES-1:0] rd_data_i,
  output logic [15:0]             reg_addr_o,
  output logic [8*DATA_BYTES-1:0] wr_data_o,
  output logic                    wr_en_o,
  output logic                    rd_en_o
);
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int CNT_W  = $clog2(DATA_BYTES + 1);

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  state_e            state;
  byte_e             kind;
  logic [3:0]        bit_cnt;
  logic [7:0]        sr;
  logic [7:0]        addr_hi;
  logic              is_read, addr_ok, master_ack;
  logic [CNT_W-1:0]  cur_w, byte_cnt, new_w;
  logic [DATA_W-1:0] wbuf, txbuf;

  reg_width_lut #(.CNT_W(CNT_W)) u_lut (
    .addr_i ({addr_hi, sr}),
    .width_o(new_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      kind       <= BY_DEV;
      bit_cnt    <= '0;
      sr         <= '0;
      addr_hi    <= '0;
      is_read    <= 1'b0;
      addr_ok    <= 1'b0;
      master_ack <= 1'b0;
      cur_w      <= '0;
      byte_cnt   <= '0;
      wbuf       <= '0;
      txbuf      <= '0;
      reg_addr_o <= '0;
      wr_data_o  <= '0;
      wr_en_o    <= 1'b0;
      rd_en_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      rd_en_o <= 1'b0;
      // capture read value in the strobe cycle, left-aligned for shifting
      if (rd_en_o) txbuf <= rd_data_i << (8 * (DATA_BYTES - 32'(cur_w)));
      if (bus_start) begin
        state   <= ST_RX;
        kind    <= BY_DEV;
        bit_cnt <= '0;
        is_read <= 1'b0;
      end else if (bus_stop) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              sr      <= {sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              state <= ST_ACK;
              unique case (kind)
                BY_DEV: begin
                  if (sr[7:1] == DEV_ADDR && (!sr[0] || addr_ok)) begin
                    is_read  <= sr[0];
                    byte_cnt <= '0;
                    rd_en_o  <= sr[0];
                    kind     <= BY_AHI;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                BY_AHI: begin
                  addr_hi <= sr;
                  kind    <= BY_ALO;
                end
                BY_ALO: begin
                  if (new_w != '0) begin
                    reg_addr_o <= {addr_hi, sr};
                    cur_w      <= new_w;
                    addr_ok    <= 1'b1;
                    byte_cnt   <= '0;
                    wbuf       <= '0;
                    kind       <= BY_DATA;
                  end else begin
                    addr_ok <= 1'b0;
                    state   <= ST_SKIP;
                  end
                end
                default: begin
                  if (byte_cnt < cur_w) begin
                    wbuf     <= {wbuf[DATA_W-9:0], sr};
                    byte_cnt <= byte_cnt + 1'b1;
                    if (CNT_W'(byte_cnt + 1'b1) == cur_w) begin
                      wr_en_o   <= 1'b1;
                      wr_data_o <= {wbuf[DATA_W-9:0], sr};
                    end
                  end else begin
                    state <= ST_SKIP;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              state   <= is_read ? ST_TX : ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              txbuf <= txbuf << 1;
              if (bit_cnt == 4'd7) begin
                bit_cnt  <= '0;
                byte_cnt <= byte_cnt + 1'b1;
                state    <= ST_TXACK;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) master_ack <= ~sda_s;
            else if (scl_fall) state <= (master_ack && byte_cnt < cur_w) ? ST_TX : ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = (state == ST_ACK) || (state == ST_TX && !txbuf[DATA_W-1]);
endmodule

// File: rtl/i2c_wide_reg_target_chk.sv
module i2c_wide_reg_target_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic        wr_en_o,
  input logic        rd_en_o,
  input logic [15:0] reg_addr_o
);
  logic addr_has_width;
  always_comb begin
    addr_has_width = (reg_addr_o >= 16'h081C && reg_addr_o <= 16'h0822 && reg_addr_o != 16'h081D)
                  || reg_addr_o == 16'h0826 || reg_addr_o == 16'h0827;
  end

  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R8
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && rd_en_o));
  // R3
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> addr_has_width);
  // R5
  wr_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $stable(reg_addr_o));
endmodule

bind i2c_wide_reg_target i2c_wide_reg_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .wr_en_o   (wr_en_o),
  .rd_en_o   (rd_en_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_wide_reg_target_tb.sv
module i2c_wide_reg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TQ = 5;
  localparam logic [6:0] DEV = 7'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en, rd_en, sda_line;
  logic [23:0] rd_data, wr_data;
  logic [15:0] reg_addr;

  int vectors = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;
  logic [15:0] last_wa;
  logic [23:0] last_wd;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  function automatic int exp_w(input logic [15:0] a);
    case (a)
      16'h0820, 16'h0821: return 3;
      16'h081C, 16'h081E, 16'h0822, 16'h0826, 16'h0827: return 2;
      16'h081F: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] wmask(input int w);
    return 24'((32'd1 << (8 * w)) - 1);
  endfunction

  function automatic logic [23:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C, a[7:0] + 8'h11} & wmask(exp_w(a));
  endfunction

  function automatic logic [15:0] addr_at(input int i);
    case (i)
      0: return 16'h0820; 1: return 16'h0821; 2: return 16'h081C; 3: return 16'h081E;
      4: return 16'h0822; 5: return 16'h0826; 6: return 16'h0827; 7: return 16'h081F;
      8: return 16'h081D; 9: return 16'h0823; 10: return 16'h0828; default: return 16'h0000;
    endcase
  endfunction

  assign rd_data = pat(reg_addr);

  i2c_wide_reg_target #(.DEV_ADDR(DEV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .rd_data_i(rd_data), .reg_addr_o(reg_addr), .wr_data_o(wr_data),
    .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  always @(negedge clk) begin
    if (wr_en) begin wr_cnt++; last_wa = reg_addr; last_wd = wr_data; end
    if (rd_en) rd_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tq; repeat (TQ) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; tq; scl_m = 1'b1; tq; sda_m = 1'b0; tq; scl_m = 1'b0; tq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tq; scl_m = 1'b1; tq; sda_m = 1'b1; tq; tq;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tq; scl_m = 1'b1; tq; tq; scl_m = 1'b0; tq;
    end
    sda_m = 1'b1; tq; scl_m = 1'b1; tq; ack = ~sda_line; tq; scl_m = 1'b0; tq;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tq; scl_m = 1'b1; tq; b[i] = sda_line; tq; scl_m = 1'b0;
    end
    tq; sda_m = ~mack; tq; scl_m = 1'b1; tq; tq; scl_m = 1'b0; tq; sda_m = 1'b1;
  endtask

  // start, device write byte, two address bytes; returns ack of low byte
  task automatic set_addr(input logic [15:0] a, output logic ack_lo);
    logic ack;
    bus_start;
    wr_byte({DEV, 1'b0}, ack); chk("R1 dev ack", 32'(ack), 1);
    wr_byte(a[15:8], ack);     chk("R2 addr hi ack", 32'(ack), 1);
    wr_byte(a[7:0], ack_lo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 oe reset", 32'(sda_oe), 0);
    chk("R11 wr reset", 32'(wr_en), 0);
    chk("R11 rd reset", 32'(rd_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [15:0] a;
      logic [23:0] d;
      int w, w0, r0;
      a = addr_at(i);
      w = exp_w(a);
      d = (24'hC3B2A1 ^ {a, a[7:0]}) & wmask(w);
      // full write plus one overlong byte
      w0 = wr_cnt;
      set_addr(a, ack);
      chk("R3/R4 addr lo ack", 32'(ack), 32'(w != 0));
      if (w != 0) begin
        for (int k = 0; k < w; k++) begin
          wr_byte(8'(d >> (8 * (w - 1 - k))), ack);
          chk("R5 data ack", 32'(ack), 1);
        end
        wr_byte(8'h5A, ack);
        chk("R7 extra byte nack", 32'(ack), 0);
      end
      bus_stop;
      chk("R5/R7 write count", 32'(wr_cnt - w0), 32'(w != 0));
      if (w != 0) begin
        chk("R5 write data", 32'(last_wd), 32'(d));
        chk("R2 write addr", 32'(last_wa), 32'(a));
      end
      // read through repeated start
      r0 = rd_cnt;
      set_addr(a, ack);
      bus_start;
      wr_byte({DEV, 1'b1}, ack);
      chk("R4/R8 read dev ack", 32'(ack), 32'(w != 0));
      if (w != 0) begin
        for (int k = 0; k < w; k++) begin
          rd_byte(b, 1'b1);
          chk("R8 read byte", 32'(b), 32'(8'(pat(a) >> (8 * (w - 1 - k)))));
        end
        rd_byte(b, 1'b0);
        chk("R9 beyond width", 32'(b), 32'hFF);
      end
      bus_stop;
      chk("R8 read strobes", 32'(rd_cnt - r0), 32'(w != 0));
      // short write
      if (w != 0) begin
        w0 = wr_cnt;
        set_addr(a, ack);
        for (int k = 0; k < w - 1; k++) wr_byte(8'h77, ack);
        bus_stop;
        chk("R6 short write", 32'(wr_cnt - w0), 0);
      end
    end

    // foreign device address
    begin
      int w0;
      w0 = wr_cnt;
      bus_start;
      wr_byte({DEV ^ 7'h01, 1'b0}, ack);
      chk("R1 foreign nack", 32'(ack), 0);
      wr_byte(8'h08, ack);
      chk("R1 ignored after nack", 32'(ack), 0);
      wr_byte(8'h1F, ack);
      wr_byte(8'h42, ack);
      bus_stop;
      chk("R1 no strobe", 32'(wr_cnt - w0), 0);
    end

    // early controller nack on a 3-byte read
    set_addr(16'h0821, ack);
    bus_start;
    wr_byte({DEV, 1'b1}, ack);
    rd_byte(b, 1'b0);
    chk("R8 first byte", 32'(b), 32'(pat(16'h0821) >> 16));
    rd_byte(b, 1'b0);
    chk("R9 after nack", 32'(b), 32'hFF);
    bus_stop;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule